// File: doc/BRIEF.md
# Single-Cycle Six-Operation RISC Core

This block is a 32-bit processor core that completes one instruction per clock period. In each cycle it reads the instruction word at the program counter and decodes it. It reads two source registers, computes in an ALU, reads or writes data memory if the instruction needs it, and selects the next program counter. The supported operations are register add and subtract without overflow detection, OR with an immediate, word load, word store, and branch on equality. The core has a 32 x 32-bit register file and two separate word-addressed memories. Both memories read combinationally.

All architectural state changes on the falling clock edge: the program counter, the register file and data memory. The bench uses the rising-edge half of the period to drive inputs and sample outputs. A load port writes instruction words into instruction memory. It is a plain write strobe with no ready signal. A word offered while `imem_ld_valid` is high is taken at the next falling edge, and there is never back-pressure. While `run` is low, the core holds all of its state, so programs can be loaded and results inspected. A combinational register-peek port shows any architectural register.

Top module: `sc_core`

## Requirements
- R1: A synchronous reset, taken at a falling edge with `rst` high, sets `pc` to 0 and clears every register to 0.
- R2: An R-type instruction (opcode 000000) with funct 100001 writes rs+rt into rd, and with funct 100011 writes rs-rt into rd. Both use 32-bit wrap-around arithmetic and have no overflow effect. Fields are opcode [31:26], rs [25:21], rt [20:16], rd [15:11] and funct [5:0].
- R3: Opcode 001101 writes rs OR the zero-extended imm [15:0] into rt.
- R4: Opcode 100011 loads the data word at rs+sign_ext(imm) into rt. Opcode 101011 stores rt at that address. Memory word index is address bits [9:2].
- R5: Opcode 000100 compares rs and rt. If they are equal, the next pc is pc+4+(sign_ext(imm)<<2); otherwise it is pc+4.
- R6: Register 0 always reads 0, and writes that target it are discarded.
- R7: Any other opcode, and any other funct under opcode 000000, changes no register or memory and advances pc by 4.
- R8: While `run` is low, pc, registers and data memory keep their values.
- R9: An instruction that reads and writes the same register uses the old value as its operand; the new value is visible from the next instruction.
- R10: A word on the load port with `imem_ld_valid` high is written at instruction word index `imem_ld_addr` at the next falling edge. The core later executes it when pc reaches that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state updates on its falling edge |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | Execute one instruction per cycle when high; hold state when low |
| imem_ld_valid | input | 1 | Instruction-memory load strobe, never back-pressured |
| imem_ld_addr | input | 8 | Word index to load |
| imem_ld_data | input | 32 | Instruction word to load |
| peek_sel | input | 5 | Register number to observe |
| peek_data | output | 32 | Current value of the selected register |
| pc | output | 32 | Current program counter (byte address) |

## Verification
The case that matters is one instruction that reads a register and also writes that same register. In a single cycle this is an operand read and a write-back to the same entry. The bench provokes it with a load whose base register is also its destination. The address is set up by a store through that base. A core that forwarded the new value, or that wrote before reading, would fetch from the wrong word. The result is judged by peeking the destination after the run and comparing it with the value stored at the old-base address.

// File: rtl/sc_core_pkg.sv
package sc_core_pkg;

  localparam logic [5:0] OPC_RTYPE = 6'b000000;
  localparam logic [5:0] OPC_ORI   = 6'b001101;
  localparam logic [5:0] OPC_LW    = 6'b100011;
  localparam logic [5:0] OPC_SW    = 6'b101011;
  localparam logic [5:0] OPC_BEQ   = 6'b000100;
  localparam logic [5:0] FN_ADDU   = 6'b100001;
  localparam logic [5:0] FN_SUBU   = 6'b100011;

  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_SUB = 2'd1,
    ALU_OR  = 2'd2
  } alu_sel_e;

  typedef struct packed {
    logic     dst_rd;    // write rd (R-type) instead of rt
    logic     src_imm;   // ALU operand B from immediate
    logic     wb_mem;    // write-back from data memory
    logic     reg_we;
    logic     mem_we;
    logic     is_branch;
    logic     sext;      // sign-extend immediate
    alu_sel_e alu;
  } ctrl_t;

endpackage

// File: rtl/sc_decoder.sv
module sc_decoder
  import sc_core_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl,
  output logic       legal
);
  always_comb begin
    ctrl  = '0;
    legal = 1'b1;
    unique case (opcode)
      OPC_RTYPE: begin
        ctrl.dst_rd = 1'b1;
        if (funct == FN_ADDU) begin
          ctrl.reg_we = 1'b1;
          ctrl.alu    = ALU_ADD;
        end else if (funct == FN_SUBU) begin
          ctrl.reg_we = 1'b1;
          ctrl.alu    = ALU_SUB;
        end else begin
          legal = 1'b0;
        end
      end
      OPC_ORI: begin
        ctrl.src_imm = 1'b1;
        ctrl.reg_we  = 1'b1;
        ctrl.alu     = ALU_OR;
      end
      OPC_LW: begin
        ctrl.src_imm = 1'b1;
        ctrl.wb_mem  = 1'b1;
        ctrl.reg_we  = 1'b1;
        ctrl.sext    = 1'b1;
        ctrl.alu     = ALU_ADD;
      end
      OPC_SW: begin
        ctrl.src_imm = 1'b1;
        ctrl.mem_we  = 1'b1;
        ctrl.sext    = 1'b1;
        ctrl.alu     = ALU_ADD;
      end
      OPC_BEQ: begin
        ctrl.is_branch = 1'b1;
        ctrl.sext      = 1'b1;
        ctrl.alu       = ALU_SUB;
      end
      default: legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_core_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_sel_e     sel,
  output logic [W-1:0] y,
  output logic         zero
);
  always_comb begin
    unique case (sel)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_OR:  y = a | b;
      default: y = '0;
    endcase
  end
  assign zero = (y == '0);
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int W = 32,
  parameter int N = 32,
  localparam int AB = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AB-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic [AB-1:0] ra1,
  input  logic [AB-1:0] ra2,
  input  logic [AB-1:0] ra3,
  output logic [W-1:0]  rd1,
  output logic [W-1:0]  rd2,
  output logic [W-1:0]  rd3
);
  logic [W-1:0] regs [N];
  logic         we_eff;

  assign we_eff = we && (wa != '0);

  always_ff @(negedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) regs[i] <= '0;
    end else if (we_eff) begin
      regs[wa] <= wd;
    end
  end

  assign rd1 = regs[ra1];
  assign rd2 = regs[ra2];
  assign rd3 = regs[ra3];

  // R6: entry 0 must still read zero after any write attempt
  a_r6_zero_reg: assert property (@(negedge clk) disable iff (rst)
    (we && wa == '0) |=> (regs[0] == '0));
  a_r6_zero_read: assert property (@(negedge clk) disable iff (rst)
    (ra3 == '0) |-> (rd3 == '0));
endmodule

// File: rtl/sc_mem.sv
module sc_mem #(
  parameter int AW = 8,
  parameter int DW = 32,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] words [DEPTH];

  always_ff @(negedge clk) begin
    if (we) words[waddr] <= wdata;
  end

  assign rdata = words[raddr];
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_core_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int IMEM_AW = 8,
  parameter int DMEM_AW = 8,
  parameter int NREG    = 32,
  localparam int RAB    = $clog2(NREG)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               run,
  input  logic               imem_ld_valid,
  input  logic [IMEM_AW-1:0] imem_ld_addr,
  input  logic [31:0]        imem_ld_data,
  input  logic [RAB-1:0]     peek_sel,
  output logic [XLEN-1:0]    peek_data,
  output logic [XLEN-1:0]    pc
);
  logic [31:0]     instr;
  ctrl_t           ctrl;
  logic            legal;
  logic            commit;
  logic [RAB-1:0]  rs_a, rt_a, rd_a, wa;
  logic [XLEN-1:0] rs_v, rt_v, imm_ext, alu_b, alu_y, dm_rdata, wb_v;
  logic [XLEN-1:0] pc_plus4, br_target;
  logic            alu_zero, taken;
  logic            unused_shamt;

  assign unused_shamt = ^instr[10:6];
  assign commit       = run && !rst;

  sc_mem #(.AW(IMEM_AW), .DW(32)) u_imem (
    .clk(clk), .we(imem_ld_valid), .waddr(imem_ld_addr), .wdata(imem_ld_data),
    .raddr(pc[IMEM_AW+1:2]), .rdata(instr)
  );

  sc_decoder u_dec (
    .opcode(instr[31:26]), .funct(instr[5:0]), .ctrl(ctrl), .legal(legal)
  );

  assign rs_a = instr[21 +: RAB];
  assign rt_a = instr[16 +: RAB];
  assign rd_a = instr[11 +: RAB];
  assign wa   = ctrl.dst_rd ? rd_a : rt_a;

  sc_regfile #(.W(XLEN), .N(NREG)) u_rf (
    .clk(clk), .rst(rst), .we(ctrl.reg_we && commit), .wa(wa), .wd(wb_v),
    .ra1(rs_a), .ra2(rt_a), .ra3(peek_sel),
    .rd1(rs_v), .rd2(rt_v), .rd3(peek_data)
  );

  assign imm_ext = ctrl.sext ? {{(XLEN-16){instr[15]}}, instr[15:0]}
                             : {{(XLEN-16){1'b0}}, instr[15:0]};
  assign alu_b   = ctrl.src_imm ? imm_ext : rt_v;

  sc_alu #(.W(XLEN)) u_alu (
    .a(rs_v), .b(alu_b), .sel(ctrl.alu), .y(alu_y), .zero(alu_zero)
  );

  sc_mem #(.AW(DMEM_AW), .DW(XLEN)) u_dmem (
    .clk(clk), .we(ctrl.mem_we && commit), .waddr(alu_y[DMEM_AW+1:2]),
    .wdata(rt_v), .raddr(alu_y[DMEM_AW+1:2]), .rdata(dm_rdata)
  );

  assign wb_v      = ctrl.wb_mem ? dm_rdata : alu_y;
  assign pc_plus4  = pc + XLEN'(4);
  assign br_target = pc_plus4 + (imm_ext << 2);
  assign taken     = ctrl.is_branch && alu_zero;

  always_ff @(negedge clk) begin
    if (rst)      pc <= '0;
    else if (run) pc <= taken ? br_target : pc_plus4;
  end

  // R1: reset clears the program counter
  a_r1_pc_cleared: assert property (@(negedge clk)
    rst |=> (pc == '0));
  // R8: held core keeps its PC
  a_r8_frozen: assert property (@(negedge clk) disable iff (rst)
    !run |=> $stable(pc));
  // R7: unknown encodings only step the PC
  a_r7_nop_step: assert property (@(negedge clk) disable iff (rst)
    (run && !legal) |=> (pc == $past(pc) + XLEN'(4)));
  // R5: equal operands redirect, unequal fall through
  a_r5_taken: assert property (@(negedge clk) disable iff (rst)
    (run && ctrl.is_branch && rs_v == rt_v)
      |=> (pc == $past(pc) + XLEN'(4) + ($past(imm_ext) << 2)));
  a_r5_not_taken: assert property (@(negedge clk) disable iff (rst)
    (run && ctrl.is_branch && rs_v != rt_v) |=> (pc == $past(pc) + XLEN'(4)));
endmodule

// File: tb/sc_core_tb.sv
module sc_core_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run = 1'b0;
  logic        imem_ld_valid = 1'b0;
  logic [7:0]  imem_ld_addr = '0;
  logic [31:0] imem_ld_data = '0;
  logic [4:0]  peek_sel = '0;
  logic [31:0] peek_data, pc;

  int checks = 0;
  int errors = 0;
  logic [31:0] prog [64];
  int plen = 0;

  always #5 clk = ~clk;

  sc_core u_dut (
    .clk(clk), .rst(rst), .run(run), .imem_ld_valid(imem_ld_valid),
    .imem_ld_addr(imem_ld_addr), .imem_ld_data(imem_ld_data),
    .peek_sel(peek_sel), .peek_data(peek_data), .pc(pc)
  );

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
    return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  localparam logic [5:0] ADDU = 6'b100001, SUBU = 6'b100011;
  localparam logic [5:0] ORI = 6'b001101, LW = 6'b100011, SW = 6'b101011, BEQ = 6'b000100;
  localparam logic [31:0] HALT = {6'b000100, 5'd0, 5'd0, 16'hFFFF};

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic check_reg(string req, int r, logic [31:0] exp);
    peek_sel = 5'(r);
    #1;
    check(req, peek_data, exp);
  endtask

  task automatic put(logic [31:0] w);
    prog[plen] = w;
    plen++;
  endtask

  // reset while loading, then release and run n instructions, then hold
  task automatic load_and_run(int n);
    @(posedge clk);
    rst = 1'b1; run = 1'b0;
    for (int i = 0; i < plen; i++) begin
      imem_ld_valid = 1'b1; imem_ld_addr = 8'(i); imem_ld_data = prog[i];
      @(posedge clk);
    end
    imem_ld_valid = 1'b0;
    @(posedge clk);
    rst = 1'b0; run = (n > 0);
    for (int i = 0; i < n; i++) @(posedge clk);
    run = 1'b0;
    #1;
    plen = 0;
  endtask

  task automatic t_reset();
    put(HALT);
    load_and_run(0);
    check("R1 pc after reset", pc, 32'h0);
    check_reg("R1 reg5 cleared", 5, 32'h0);
    check_reg("R1 reg31 cleared", 31, 32'h0);
  endtask

  task automatic t_arith();
    put(enc_i(ORI, 0, 1, 16'h0001));
    put(enc_r(0, 1, 2, SUBU));   // 0-1
    put(enc_r(2, 1, 3, ADDU));   // -1+1 wraps
    put(enc_r(2, 2, 4, ADDU));
    put(enc_r(1, 2, 5, SUBU));   // 1-(-1)
    put(HALT);
    load_and_run(8);
    check_reg("R2 subu wrap", 2, 32'hFFFF_FFFF);
    check_reg("R2 addu wrap", 3, 32'h0);
    check_reg("R2 addu neg", 4, 32'hFFFF_FFFE);
    check_reg("R2 subu", 5, 32'h2);
  endtask

  task automatic t_ori();
    put(enc_i(ORI, 0, 1, 16'h8000));
    put(enc_i(ORI, 1, 2, 16'h00F0));
    put(HALT);
    load_and_run(5);
    check_reg("R3 zero-extend", 1, 32'h0000_8000);
    check_reg("R3 or with reg", 2, 32'h0000_80F0);
  endtask

  task automatic t_mem();
    put(enc_i(ORI, 0, 1, 16'h0040));
    put(enc_i(ORI, 0, 2, 16'h1234));
    put(enc_i(SW, 1, 2, 16'h0004));
    put(enc_i(SW, 1, 1, 16'hFFFC));  // negative offset, address 0x3C
    put(enc_i(LW, 1, 3, 16'h0004));
    put(enc_i(LW, 1, 4, 16'hFFFC));
    put(HALT);
    load_and_run(9);
    check_reg("R4 load positive offset", 3, 32'h1234);
    check_reg("R4 load negative offset", 4, 32'h40);
  endtask

  task automatic t_branch();
    put(enc_i(ORI, 0, 1, 16'd5));      // 0
    put(enc_i(ORI, 0, 2, 16'd5));      // 4
    put(enc_i(BEQ, 1, 2, 16'd2));      // 8 -> 20
    put(enc_i(ORI, 0, 3, 16'hBAD));    // 12
    put(enc_i(ORI, 0, 3, 16'hBAD));    // 16
    put(enc_i(ORI, 0, 4, 16'd7));      // 20
    put(enc_i(BEQ, 1, 4, 16'd1));      // 24 not taken
    put(enc_i(ORI, 0, 5, 16'd9));      // 28
    put(HALT);                         // 32
    load_and_run(12);
    check_reg("R5 skipped by taken branch", 3, 32'h0);
    check_reg("R5 branch target executed", 4, 32'd7);
    check_reg("R5 fall-through executed", 5, 32'd9);
    check("R5 backward self-branch pc", pc, 32'd32);
  endtask

  task automatic t_zero();
    put(enc_i(ORI, 0, 0, 16'h0055));
    put(enc_r(0, 0, 1, ADDU));
    put(HALT);
    load_and_run(4);
    check_reg("R6 reg0 reads zero", 0, 32'h0);
    check_reg("R6 reg0 source is zero", 1, 32'h0);
  endtask

  task automatic t_nop();
    put(enc_i(ORI, 0, 1, 16'd3));
    put(32'hFC22_0000);                 // opcode 111111 targeting reg2
    put(enc_r(1, 1, 2, 6'b100000));     // unsupported funct
    put(HALT);
    load_and_run(3);
    check("R7 pc stepped over nops", pc, 32'd12);
    check_reg("R7 no write by nops", 2, 32'h0);
    check_reg("R7 prior reg intact", 1, 32'd3);
  endtask

  task automatic t_hold();
    put(enc_i(ORI, 0, 1, 16'h0011));
    put(HALT);
    load_and_run(0);
    repeat (5) @(posedge clk);
    #1;
    check("R8 pc held", pc, 32'h0);
    check_reg("R8 reg held", 1, 32'h0);
    @(posedge clk); run = 1'b1;
    @(posedge clk); run = 1'b0;
    #1;
    check("R8 single step pc", pc, 32'h4);
    check_reg("R8 single step reg", 1, 32'h11);
  endtask

  task automatic t_same_reg();
    put(enc_i(ORI, 0, 3, 16'h0080));
    put(enc_i(ORI, 0, 4, 16'h0099));
    put(enc_i(SW, 3, 4, 16'h0004));   // [0x84] = 0x99
    put(enc_i(LW, 3, 3, 16'h0004));   // base is old r3
    put(enc_r(4, 4, 4, SUBU));        // r4 = r4 - r4
    put(HALT);
    load_and_run(7);
    check_reg("R9 load through own base", 3, 32'h99);
    check_reg("R9 subu self", 4, 32'h0);
  endtask

  task automatic t_reload();
    put(enc_i(ORI, 0, 1, 16'h0001));
    put(HALT);
    load_and_run(0);
    put(enc_i(ORI, 0, 1, 16'h0002));  // overwrite word 0
    load_and_run(3);
    check_reg("R10 reloaded word executed", 1, 32'h2);
    check("R10 pc at halt", pc, 32'h4);
  endtask

  initial begin
    #2ms;
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_arith();
    t_ori();
    t_mem();
    t_branch();
    t_zero();
    t_nop();
    t_hold();
    t_same_reg();
    t_reload();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule